// File: doc/BRIEF.md
# Pipeline Forwarding and Load-Stall Controller

This block resolves data hazards for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It takes the source and destination register numbers and the control bits of the instruction currently in decode. It registers them into the decode/execute stage register, and then carries the control bits and the chosen destination number down through the execute/memory and memory/writeback stage registers. The register file, ALU, memories and instruction decoder stay outside the block.

Each cycle the block compares the source numbers of the instruction in execute with the destinations held further down the pipe. It produces a two-bit select code for each ALU operand multiplexer. A load whose target is needed by the very next instruction cannot be covered by forwarding. In that case the block raises a fetch-hold output, which freezes the program counter and the fetch/decode register. In the same cycle it zeroes the control bits entering the decode/execute register, so the stalled instruction is decoded again one cycle later behind a bubble.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, every carried control bit is cleared. After that edge, `ex_alu_ctl`, `mem_rd_en`, `mem_wr_en`, `wb_reg_write` and `wb_mem_to_reg` read 0, whatever the decode inputs are.
- R2: Control bits presented at decode appear at the execute outputs one edge later, at the memory outputs two edges later and at the writeback outputs three edges later. The destination number travels with them: it is `dec_rd` when `dec_reg_dst` is 1 and `dec_rt` when it is 0.
- R3: `fwd_a_sel` is 2'b10 (take the memory-stage result) when the memory-stage instruction writes a register whose number equals the execute-stage source A number.
- R4: `fwd_b_sel` is 2'b10 under the same condition, compared against the execute-stage source B number.
- R5: A select is 2'b01 (take the writeback-stage result) when the writeback-stage instruction writes a register equal to that operand's source number and R3/R4 do not apply.
- R6: When the memory stage and the writeback stage both match one source, the select is 2'b10, so the newer value wins.
- R7: No forwarding occurs from a stage whose register-write bit is 0 or whose destination is register 0. The select then reads 2'b00 (register file).
- R8: A producer three instructions ahead of its consumer has left the pipe by the time the consumer executes. Both selects then read 2'b00, because the register file writes early and reads late in the cycle.
- R9: `hold_fetch` is high, in the same cycle, exactly when the execute-stage instruction has its memory-read bit set and its source B number equals the decode source A or source B number.
- R10: In the cycle after `hold_fetch`, the execute-stage control bits are all zero, and that bubble reaches the memory and writeback outputs with all bits zero. When decode presents the held instruction again, it does not stall a second time.
- R11: After the bubble, the instruction that was held gets the loaded value by forwarding from the writeback stage (select 2'b01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_rs | input | REG_W | Source A register number of the decode instruction |
| dec_rt | input | REG_W | Source B register number of the decode instruction |
| dec_rd | input | REG_W | Third register number of the decode instruction |
| dec_reg_dst | input | 1 | 1: destination is dec_rd, 0: destination is dec_rt |
| dec_alu_ctl | input | ALU_CTL_W | ALU operation bits for the execute stage |
| dec_mem_read | input | 1 | Instruction reads data memory (load) |
| dec_mem_write | input | 1 | Instruction writes data memory |
| dec_reg_write | input | 1 | Instruction writes the register file |
| dec_mem_to_reg | input | 1 | Writeback takes the memory data rather than the ALU result |
| fwd_a_sel | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 writeback stage |
| fwd_b_sel | output | 2 | Operand B select, same encoding |
| hold_fetch | output | 1 | Freeze the program counter and the fetch/decode register |
| ex_alu_ctl | output | ALU_CTL_W | ALU operation bits in the execute stage |
| ex_dest | output | REG_W | Destination number chosen in the execute stage |
| mem_rd_en | output | 1 | Memory-stage read enable |
| mem_wr_en | output | 1 | Memory-stage write enable |
| mem_dest | output | REG_W | Destination number in the memory stage |
| wb_reg_write | output | 1 | Register-file write enable from the writeback stage |
| wb_mem_to_reg | output | 1 | Writeback data select from the writeback stage |
| wb_dest | output | REG_W | Register-file write address from the writeback stage |

## Verification
A stale or corrupted stage register shows up at the outputs within one to three edges. A wrong execute-stage entry corrupts `ex_alu_ctl`, `ex_dest` and both selects in the very next cycle. A wrong memory-stage entry shows on the memory enables and on a 2'b10 select one edge after issue of the consumer. A wrong writeback entry shows on the register-file write port and on a 2'b01 select. A bubble that is not cleared would appear as a nonzero ALU code one cycle after `hold_fetch`, and as a spurious memory or register write one and two cycles after that. Those cycles are what the checks sample.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Operand source codes driven onto the ALU input multiplexers.
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  // Bits consumed in the writeback stage.
  typedef struct packed {
    logic reg_write;
    logic mem_to_reg;
  } wb_ctl_t;

  // Bits consumed in the memory stage.
  typedef struct packed {
    logic mem_read;
    logic mem_write;
  } mem_ctl_t;

  // Newer stage first: a memory-stage hit overrides a writeback-stage hit.
  function automatic fwd_sel_e fwd_code(input logic mem_hit, input logic wb_hit);
    if (mem_hit)     return FWD_MEM;
    else if (wb_hit) return FWD_WB;
    else             return FWD_RF;
  endfunction

endpackage

// File: rtl/hz_pipe_reg.sv
// Generic stage register: synchronous reset, plus an optional clear that
// loads zero (used to inject a bubble).
module hz_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else            q <= d;
  end
endmodule

// File: rtl/hz_fwd_sel.sv
// One select code per ALU operand, from register-number comparison.
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int N_OPS = 2
) (
  input  logic [N_OPS-1:0][REG_W-1:0] src_num,
  input  logic                        mem_reg_write,
  input  logic [REG_W-1:0]            mem_dest,
  input  logic                        wb_reg_write,
  input  logic [REG_W-1:0]            wb_dest,
  output logic [N_OPS-1:0][1:0]       sel,
  output logic [N_OPS-1:0]            mem_hit,
  output logic [N_OPS-1:0]            wb_hit
);
  // A producer counts only if it writes and its target is not register 0.
  function automatic logic live_match(input logic wr, input logic [REG_W-1:0] dst,
                                      input logic [REG_W-1:0] src);
    return wr && (dst != '0) && (dst == src);
  endfunction

  for (genvar i = 0; i < N_OPS; i++) begin : g_op
    assign mem_hit[i] = live_match(mem_reg_write, mem_dest, src_num[i]);
    assign wb_hit[i]  = live_match(wb_reg_write, wb_dest, src_num[i]);
    assign sel[i]     = fwd_code(mem_hit[i], wb_hit[i]);
  end
endmodule

// File: rtl/hz_load_use.sv
// Load followed immediately by a consumer of its result.
module hz_load_use #(
  parameter int REG_W = 5
) (
  input  logic             ex_mem_read,
  input  logic [REG_W-1:0] ex_rt,
  input  logic [REG_W-1:0] dec_rs,
  input  logic [REG_W-1:0] dec_rt,
  output logic             hold
);
  function automatic logic needs_stall(input logic ld, input logic [REG_W-1:0] ld_dst,
                                       input logic [REG_W-1:0] a, input logic [REG_W-1:0] b);
    return ld && ((ld_dst == a) || (ld_dst == b));
  endfunction

  assign hold = needs_stall(ex_mem_read, ex_rt, dec_rs, dec_rt);
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
  import hz_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int ALU_CTL_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [REG_W-1:0]     dec_rs,
  input  logic [REG_W-1:0]     dec_rt,
  input  logic [REG_W-1:0]     dec_rd,
  input  logic                 dec_reg_dst,
  input  logic [ALU_CTL_W-1:0] dec_alu_ctl,
  input  logic                 dec_mem_read,
  input  logic                 dec_mem_write,
  input  logic                 dec_reg_write,
  input  logic                 dec_mem_to_reg,
  output logic [1:0]           fwd_a_sel,
  output logic [1:0]           fwd_b_sel,
  output logic                 hold_fetch,
  output logic [ALU_CTL_W-1:0] ex_alu_ctl,
  output logic [REG_W-1:0]     ex_dest,
  output logic                 mem_rd_en,
  output logic                 mem_wr_en,
  output logic [REG_W-1:0]     mem_dest,
  output logic                 wb_reg_write,
  output logic                 wb_mem_to_reg,
  output logic [REG_W-1:0]     wb_dest
);
  localparam int WB_W    = $bits(wb_ctl_t);
  localparam int MEM_W   = $bits(mem_ctl_t);
  localparam int IDX_C_W = 1 + ALU_CTL_W + MEM_W + WB_W;
  localparam int IDX_S_W = 3 * REG_W;
  localparam int EXM_W   = MEM_W + WB_W + REG_W;
  localparam int MWB_W   = WB_W + REG_W;
  localparam int N_OPS   = 2;

  // ---------------- decode/execute ----------------
  wb_ctl_t  dec_wb, ex_wb;
  mem_ctl_t dec_mem, ex_mem;
  logic     ex_reg_dst;
  logic [REG_W-1:0] ex_rs, ex_rt, ex_rd;
  logic     bubble;  // named event: control fields of decode/execute cleared

  assign dec_wb  = '{reg_write: dec_reg_write, mem_to_reg: dec_mem_to_reg};
  assign dec_mem = '{mem_read: dec_mem_read, mem_write: dec_mem_write};
  assign bubble  = hold_fetch;

  hz_pipe_reg #(.W(IDX_C_W)) u_idex_ctl (
    .clk (clk),
    .rst (rst),
    .clr (bubble),
    .d   ({dec_reg_dst, dec_alu_ctl, dec_mem, dec_wb}),
    .q   ({ex_reg_dst, ex_alu_ctl, ex_mem, ex_wb})
  );

  // Register numbers load even during a bubble; with zero control they are inert.
  hz_pipe_reg #(.W(IDX_S_W)) u_idex_num (
    .clk (clk),
    .rst (rst),
    .clr (1'b0),
    .d   ({dec_rs, dec_rt, dec_rd}),
    .q   ({ex_rs, ex_rt, ex_rd})
  );

  assign ex_dest = ex_reg_dst ? ex_rd : ex_rt;

  // ---------------- execute/memory ----------------
  wb_ctl_t  mem_wb;
  mem_ctl_t mem_ctl;

  hz_pipe_reg #(.W(EXM_W)) u_exmem (
    .clk (clk),
    .rst (rst),
    .clr (1'b0),
    .d   ({ex_mem, ex_wb, ex_dest}),
    .q   ({mem_ctl, mem_wb, mem_dest})
  );

  assign mem_rd_en = mem_ctl.mem_read;
  assign mem_wr_en = mem_ctl.mem_write;

  // ---------------- memory/writeback ----------------
  wb_ctl_t wb_ctl;

  hz_pipe_reg #(.W(MWB_W)) u_memwb (
    .clk (clk),
    .rst (rst),
    .clr (1'b0),
    .d   ({mem_wb, mem_dest}),
    .q   ({wb_ctl, wb_dest})
  );

  assign wb_reg_write  = wb_ctl.reg_write;
  assign wb_mem_to_reg = wb_ctl.mem_to_reg;

  // ---------------- forwarding ----------------
  logic [N_OPS-1:0][1:0] op_sel;
  logic [N_OPS-1:0]      mem_hit, wb_hit;

  hz_fwd_sel #(.REG_W(REG_W), .N_OPS(N_OPS)) u_fwd (
    .src_num       ({ex_rt, ex_rs}),
    .mem_reg_write (mem_wb.reg_write),
    .mem_dest      (mem_dest),
    .wb_reg_write  (wb_ctl.reg_write),
    .wb_dest       (wb_dest),
    .sel           (op_sel),
    .mem_hit       (mem_hit),
    .wb_hit        (wb_hit)
  );

  assign fwd_a_sel = op_sel[0];
  assign fwd_b_sel = op_sel[1];

  // ---------------- load-use stall ----------------
  hz_load_use #(.REG_W(REG_W)) u_ldu (
    .ex_mem_read (ex_mem.mem_read),
    .ex_rt       (ex_rt),
    .dec_rs      (dec_rs),
    .dec_rt      (dec_rt),
    .hold        (hold_fetch)
  );

endmodule

// File: rtl/pipe_hazard_ctl_chk.sv
module pipe_hazard_ctl_chk #(
  parameter int REG_W     = 5,
  parameter int ALU_CTL_W = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           fwd_a_sel,
  input logic [1:0]           fwd_b_sel,
  input logic                 hold_fetch,
  input logic [ALU_CTL_W-1:0] ex_alu_ctl,
  input logic                 ex_ld,
  input logic                 ex_st,
  input logic                 ex_rw,
  input logic [REG_W-1:0]     ex_rs,
  input logic [REG_W-1:0]     ex_rt,
  input logic                 mem_rw,
  input logic                 mem_rd_en,
  input logic                 mem_wr_en,
  input logic [REG_W-1:0]     mem_dest,
  input logic                 wb_reg_write,
  input logic [REG_W-1:0]     wb_dest
);
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!wb_reg_write && !mem_rd_en && !mem_wr_en && ex_alu_ctl == '0));

  p_wb_follows_mem_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (wb_reg_write == $past(mem_rw) && wb_dest == $past(mem_dest)));

  p_mem_fwd_a_r3: assert property (@(posedge clk) disable iff (rst)
    fwd_a_sel == 2'b10 |-> (mem_rw && mem_dest != '0 && mem_dest == ex_rs));

  p_mem_fwd_b_r4: assert property (@(posedge clk) disable iff (rst)
    fwd_b_sel == 2'b10 |-> (mem_rw && mem_dest != '0 && mem_dest == ex_rt));

  p_wb_fwd_b_r5: assert property (@(posedge clk) disable iff (rst)
    fwd_b_sel == 2'b01 |-> (wb_reg_write && wb_dest != '0 && wb_dest == ex_rt));

  p_sel_code_legal_r6: assert property (@(posedge clk) disable iff (rst)
    (fwd_a_sel != 2'b11) && (fwd_b_sel != 2'b11));

  p_stall_needs_load_r9: assert property (@(posedge clk) disable iff (rst)
    hold_fetch |-> ex_ld);

  p_bubble_zero_r10: assert property (@(posedge clk) disable iff (rst)
    hold_fetch |=> (ex_alu_ctl == '0 && !ex_ld && !ex_st && !ex_rw));

  p_single_stall_r10: assert property (@(posedge clk) disable iff (rst)
    hold_fetch |=> !hold_fetch);
endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(.REG_W(REG_W), .ALU_CTL_W(ALU_CTL_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .fwd_a_sel    (fwd_a_sel),
  .fwd_b_sel    (fwd_b_sel),
  .hold_fetch   (hold_fetch),
  .ex_alu_ctl   (ex_alu_ctl),
  .ex_ld        (ex_mem.mem_read),
  .ex_st        (ex_mem.mem_write),
  .ex_rw        (ex_wb.reg_write),
  .ex_rs        (ex_rs),
  .ex_rt        (ex_rt),
  .mem_rw       (mem_wb.reg_write),
  .mem_rd_en    (mem_rd_en),
  .mem_wr_en    (mem_wr_en),
  .mem_dest     (mem_dest),
  .wb_reg_write (wb_reg_write),
  .wb_dest      (wb_dest)
);

// File: tb/pipe_hazard_ctl_test.sv
`timescale 1ns/1ps
module pipe_hazard_ctl_test;
  localparam int REG_W = 5;
  localparam int ALU_CTL_W = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst;
  logic [REG_W-1:0] dec_rs, dec_rt, dec_rd;
  logic dec_reg_dst, dec_mem_read, dec_mem_write, dec_reg_write, dec_mem_to_reg;
  logic [ALU_CTL_W-1:0] dec_alu_ctl;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic hold_fetch, mem_rd_en, mem_wr_en, wb_reg_write, wb_mem_to_reg;
  logic [ALU_CTL_W-1:0] ex_alu_ctl;
  logic [REG_W-1:0] ex_dest, mem_dest, wb_dest;

  pipe_hazard_ctl #(.REG_W(REG_W), .ALU_CTL_W(ALU_CTL_W)) uut (
    .clk(clk), .rst(rst), .dec_rs(dec_rs), .dec_rt(dec_rt), .dec_rd(dec_rd),
    .dec_reg_dst(dec_reg_dst), .dec_alu_ctl(dec_alu_ctl), .dec_mem_read(dec_mem_read),
    .dec_mem_write(dec_mem_write), .dec_reg_write(dec_reg_write),
    .dec_mem_to_reg(dec_mem_to_reg), .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
    .hold_fetch(hold_fetch), .ex_alu_ctl(ex_alu_ctl), .ex_dest(ex_dest),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_dest(mem_dest),
    .wb_reg_write(wb_reg_write), .wb_mem_to_reg(wb_mem_to_reg), .wb_dest(wb_dest)
  );

  // Observed signal identifiers for the scoreboard.
  localparam int S_FA = 0, S_FB = 1, S_HOLD = 2, S_EXALU = 3, S_EXDST = 4,
                 S_MRD = 5, S_MWR = 6, S_MDST = 7, S_WBRW = 8, S_WBM2R = 9, S_WBDST = 10;

  typedef struct {
    int    at;
    int    sig;
    int    exp;
    string req;
  } exp_t;

  exp_t sbq[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int observe(input int sig);
    case (sig)
      S_FA:    return int'(fwd_a_sel);
      S_FB:    return int'(fwd_b_sel);
      S_HOLD:  return int'(hold_fetch);
      S_EXALU: return int'(ex_alu_ctl);
      S_EXDST: return int'(ex_dest);
      S_MRD:   return int'(mem_rd_en);
      S_MWR:   return int'(mem_wr_en);
      S_MDST:  return int'(mem_dest);
      S_WBRW:  return int'(wb_reg_write);
      S_WBM2R: return int'(wb_mem_to_reg);
      S_WBDST: return int'(wb_dest);
      default: return -1;
    endcase
  endfunction

  task automatic expect_at(input int at, input int sig, input int exp, input string req);
    exp_t e;
    e.at = at; e.sig = sig; e.exp = exp; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic direct_check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: compares every expectation due in the current cycle.
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = sbq.size() - 1; i >= 0; i--) begin
        if (sbq[i].at == cyc) begin
          checks++;
          if (observe(sbq[i].sig) != sbq[i].exp) begin
            errors++;
            $display("FAIL %s (cycle %0d sig %0d): actual %0d expected %0d",
                     sbq[i].req, cyc, sbq[i].sig, observe(sbq[i].sig), sbq[i].exp);
          end
          sbq.delete(i);
        end
      end
    end
  end

  // Driver: presents one decode instruction for one cycle; c is that cycle.
  task automatic issue(input int rs, input int rt, input int rd, input bit rdst, input int alu,
                       input bit mr, input bit mw, input bit rw, input bit m2r, output int c);
    @(posedge clk);
    #1;
    dec_rs = rs[REG_W-1:0]; dec_rt = rt[REG_W-1:0]; dec_rd = rd[REG_W-1:0];
    dec_reg_dst = rdst; dec_alu_ctl = alu[ALU_CTL_W-1:0];
    dec_mem_read = mr; dec_mem_write = mw; dec_reg_write = rw; dec_mem_to_reg = m2r;
    c = cyc;
  endtask

  task automatic nops(input int n);
    int c;
    for (int k = 0; k < n; k++) issue(0, 0, 0, 0, 0, 0, 0, 0, 0, c);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c, c2;
    rst = 1'b1;
    // Busy decode inputs during reset: nothing may propagate (R1).
    dec_rs = 5'd3; dec_rt = 5'd3; dec_rd = 5'd3; dec_reg_dst = 1'b1; dec_alu_ctl = 4'hF;
    dec_mem_read = 1'b1; dec_mem_write = 1'b1; dec_reg_write = 1'b1; dec_mem_to_reg = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    direct_check("R1 ex_alu_ctl", int'(ex_alu_ctl), 0);
    direct_check("R1 mem_rd_en", int'(mem_rd_en), 0);
    direct_check("R1 mem_wr_en", int'(mem_wr_en), 0);
    direct_check("R1 wb_reg_write", int'(wb_reg_write), 0);
    direct_check("R1 wb_mem_to_reg", int'(wb_mem_to_reg), 0);
    @(posedge clk);
    #1;
    rst = 1'b0;
    dec_rs = '0; dec_rt = '0; dec_rd = '0; dec_reg_dst = 1'b0; dec_alu_ctl = '0;
    dec_mem_read = 1'b0; dec_mem_write = 1'b0; dec_reg_write = 1'b0; dec_mem_to_reg = 1'b0;
    nops(3);

    // R2: control and destination travel; store picks rt as destination.
    issue(1, 2, 3, 1, 5, 0, 0, 1, 0, c);
    expect_at(c + 1, S_EXALU, 5, "R2");
    expect_at(c + 1, S_EXDST, 3, "R2");
    expect_at(c + 2, S_MDST, 3, "R2");
    expect_at(c + 2, S_MRD, 0, "R2");
    expect_at(c + 3, S_WBRW, 1, "R2");
    expect_at(c + 3, S_WBM2R, 0, "R2");
    expect_at(c + 3, S_WBDST, 3, "R2");
    issue(4, 6, 9, 0, 2, 0, 1, 0, 0, c2);
    expect_at(c2 + 1, S_EXDST, 6, "R2");
    expect_at(c2 + 1, S_FA, 0, "R7 unrelated");
    expect_at(c2 + 1, S_FB, 0, "R7 unrelated");
    expect_at(c2 + 2, S_MWR, 1, "R2");
    nops(4);

    // R3: memory-stage forward to operand A.
    issue(1, 1, 7, 1, 1, 0, 0, 1, 0, c);
    issue(7, 8, 20, 1, 1, 0, 0, 1, 0, c2);
    expect_at(c2 + 1, S_FA, 2, "R3");
    expect_at(c2 + 1, S_FB, 0, "R3");
    nops(4);

    // R4: memory-stage forward to operand B.
    issue(1, 1, 9, 1, 1, 0, 0, 1, 0, c);
    issue(1, 9, 21, 1, 1, 0, 0, 1, 0, c2);
    expect_at(c2 + 1, S_FB, 2, "R4");
    expect_at(c2 + 1, S_FA, 0, "R4");
    nops(4);

    // R5: writeback-stage forward, both operands.
    issue(1, 1, 10, 1, 1, 0, 0, 1, 0, c);
    nops(1);
    issue(10, 10, 22, 1, 1, 0, 0, 1, 0, c2);
    expect_at(c2 + 1, S_FA, 1, "R5");
    expect_at(c2 + 1, S_FB, 1, "R5");
    nops(4);

    // R6: both stages match; newer wins.
    issue(1, 1, 11, 1, 1, 0, 0, 1, 0, c);
    issue(1, 1, 11, 1, 2, 0, 0, 1, 0, c);
    issue(11, 11, 23, 1, 1, 0, 0, 1, 0, c2);
    expect_at(c2 + 1, S_FA, 2, "R6");
    expect_at(c2 + 1, S_FB, 2, "R6");
    nops(4);

    // R7: no write enable, then destination register 0.
    issue(1, 1, 12, 1, 1, 0, 0, 0, 0, c);
    issue(12, 12, 24, 1, 1, 0, 0, 1, 0, c2);
    expect_at(c2 + 1, S_FA, 0, "R7 no write");
    expect_at(c2 + 1, S_FB, 0, "R7 no write");
    nops(4);
    issue(1, 1, 0, 1, 1, 0, 0, 1, 0, c);
    issue(0, 0, 25, 1, 1, 0, 0, 1, 0, c2);
    expect_at(c2 + 1, S_FA, 0, "R7 reg zero");
    expect_at(c2 + 1, S_FB, 0, "R7 reg zero");
    nops(4);

    // R8: producer three ahead, no forwarding needed.
    issue(1, 1, 13, 1, 1, 0, 0, 1, 0, c);
    nops(2);
    issue(13, 13, 26, 1, 1, 0, 0, 1, 0, c2);
    expect_at(c2 + 1, S_FA, 0, "R8");
    expect_at(c2 + 1, S_FB, 0, "R8");
    nops(4);

    // R9/R10/R11: load then immediate use via source A.
    issue(1, 14, 0, 0, 3, 1, 0, 1, 1, c);           // load into r14
    issue(14, 2, 15, 1, 6, 0, 0, 1, 0, c2);         // consumer
    expect_at(c2, S_HOLD, 1, "R9 use on A");
    issue(14, 2, 15, 1, 6, 0, 0, 1, 0, c2);         // held instruction re-presented
    expect_at(c2, S_HOLD, 0, "R10 no second stall");
    expect_at(c2, S_EXALU, 0, "R10 bubble ex");
    expect_at(c2 + 1, S_MRD, 0, "R10 bubble mem");
    expect_at(c2 + 1, S_MWR, 0, "R10 bubble mem");
    expect_at(c2 + 2, S_WBRW, 0, "R10 bubble wb");
    expect_at(c2 + 1, S_FA, 1, "R11");
    expect_at(c2 + 1, S_EXALU, 6, "R11");
    expect_at(c2 + 1, S_WBRW, 1, "R2 load wb");
    expect_at(c2 + 1, S_WBM2R, 1, "R2 load wb");
    expect_at(c2 + 1, S_WBDST, 14, "R2 load wb");
    nops(4);

    // R9: use via source B stalls.
    issue(1, 16, 0, 0, 3, 1, 0, 1, 1, c);
    issue(3, 16, 17, 1, 6, 0, 0, 1, 0, c2);
    expect_at(c2, S_HOLD, 1, "R9 use on B");
    issue(3, 16, 17, 1, 6, 0, 0, 1, 0, c2);
    expect_at(c2, S_HOLD, 0, "R10 no second stall");
    expect_at(c2 + 1, S_FB, 1, "R11 operand B");
    nops(4);

    // R9: load result not used, no stall.
    issue(1, 17, 0, 0, 3, 1, 0, 1, 1, c);
    issue(1, 2, 18, 1, 6, 0, 0, 1, 0, c2);
    expect_at(c2, S_HOLD, 0, "R9 unused load");
    nops(4);

    // R9: non-load producer with match, forward instead of stall.
    issue(1, 18, 0, 0, 3, 0, 0, 1, 0, c);
    issue(18, 2, 19, 1, 6, 0, 0, 1, 0, c2);
    expect_at(c2, S_HOLD, 0, "R9 not a load");
    expect_at(c2 + 1, S_FA, 2, "R3 non-load producer");
    nops(6);

    @(negedge clk);
    if (sbq.size() != 0) begin
      errors += sbq.size();
      $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule